// File: doc/BRIEF.md
# Single-Cycle Processor Core

This block is a 32-bit processor that completes one instruction in every clock cycle. Each cycle it fetches a word from its instruction memory at the program counter, splits the word into its fields, reads two source registers, runs the ALU, optionally reads or writes its data memory, writes a result back to the register file and picks the next program counter. The supported operations are register-to-register add, subtract, AND, OR and signed set-less-than, word load, word store, branch-on-equal and an absolute jump within the current 256 MB region.

The instruction memory is a fixed on-chip table built when the design is compiled, from a program written in the shared package. The data memory is an internal array that reset fills with a known seed pattern, so the program has nonzero operands to work on. The only other interfaces are an active-low reset and a debug port that shows the program counter and any one register chosen by a select input.

Top module: `sc_cpu_core`

## Requirements
- R1: While rst_n is low the program counter reads 0 at once, without waiting for a clock edge. After rst_n rises, the core starts fetching at address 0 and the PC reaches 4 within three rising edges.
- R2: Reset loads data memory word i with the value i*8-20 (32-bit two's complement), and a later reset restores that pattern even after stores have changed it.
- R3: Any instruction that is not a taken branch or a jump moves the PC to PC+4.
- R4: Opcode 000000 is register type: funct 100000 gives rs+rt, 100010 gives rs-rt, 100100 gives rs AND rt, 100101 gives rs OR rt, and 101010 gives 1 if rs is below rt as signed numbers and 0 otherwise. The result is written to register rd (bits 15:11).
- R5: Opcode 100011 loads the data word at rs plus the sign-extended immediate (bits 15:0) into register rt (bits 20:16). The word index is address bits [N+1:2] for a memory of 2^N words.
- R6: Opcode 101011 stores register rt at rs plus the sign-extended immediate, writes no register, and a load in the next cycle sees the new word.
- R7: Opcode 000100 compares rs with rt. When they are equal, the next PC is PC+4 plus the sign-extended immediate shifted left by 2, including negative offsets. When they differ, the next PC is PC+4. The instruction writes no register.
- R8: Opcode 000010 sets the PC to bits 31:28 of PC+4, followed by instruction bits 25:0, followed by two zero bits. It writes neither a register nor memory.
- R9: Register 0 reads as zero, and any write to it is dropped.
- R10: dbg_reg shows register dbg_sel combinationally, and dbg_pc shows the current PC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, rising edge active |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside |
| dbg_sel | input | 5 | Register number shown on dbg_reg |
| dbg_reg | output | 32 | Contents of the selected register |
| dbg_pc | output | 32 | Current program counter |

## Verification
The hardest cases to reach from the ports are those that depend on memory history rather than on a single instruction. One is a load that must return a word stored by the instruction just before it. Another is a store through a negative offset from a register base. A third is a data memory that must be reseeded by a reset arriving in the middle of a run. The built-in program stores a computed value and reloads it in the next cycle, and then overwrites a seeded word through a negative offset. It also skips instructions with a forward branch and a jump, and parks in a one-instruction backward-branch loop. The bench follows the PC cycle by cycle against the path it expects. It then pulls reset in the middle of the loop and reruns the program. A register loaded from the overwritten word must then show the original seed value again.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

  localparam int XLEN = 32;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_LOAD  = 6'b100011;
  localparam logic [5:0] OP_STORE = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_JUMP  = 6'b000010;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [1:0] {
    ALUOP_ADD   = 2'b00,
    ALUOP_SUB   = 2'b01,
    ALUOP_FUNCT = 2'b10
  } alu_op_e;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b010,
    ALU_ADD = 3'b100,
    ALU_SUB = 3'b101,
    ALU_SLT = 3'b111
  } alu_sel_e;

  typedef struct packed {
    logic    reg_write;
    logic    alu_src;
    logic    mem_to_reg;
    logic    reg_dst;
    logic    mem_read;
    logic    mem_write;
    logic    branch;
    logic    jump;
    alu_op_e alu_op;
  } ctrl_t;

  function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                        input logic [4:0] rd, input logic [5:0] fn);
    return {OP_RTYPE, rs, rt, rd, 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] enc_j(input logic [25:0] tgt);
    return {OP_JUMP, tgt};
  endfunction

  // Seed pattern for the data memory: word i = i*8 - 20
  function automatic logic [31:0] seed_word(input int idx);
    return 32'(idx * 8 - 20);
  endfunction

  // Built-in program, indexed by instruction word
  function automatic logic [31:0] boot_word(input int idx);
    case (idx)
      0:  return enc_i(OP_LOAD,  5'd0,  5'd1,  16'd0);
      1:  return enc_i(OP_LOAD,  5'd0,  5'd2,  16'd8);
      2:  return enc_i(OP_LOAD,  5'd0,  5'd3,  16'd20);
      3:  return enc_r(5'd1, 5'd3, 5'd4, FN_ADD);
      4:  return enc_r(5'd3, 5'd2, 5'd5, FN_SUB);
      5:  return enc_r(5'd1, 5'd3, 5'd6, FN_AND);
      6:  return enc_r(5'd1, 5'd3, 5'd7, FN_OR);
      7:  return enc_r(5'd1, 5'd3, 5'd8, FN_SLT);
      8:  return enc_r(5'd3, 5'd1, 5'd9, FN_SLT);
      9:  return enc_r(5'd3, 5'd3, 5'd0, FN_ADD);
      10: return enc_i(OP_STORE, 5'd0,  5'd5,  16'd36);
      11: return enc_i(OP_LOAD,  5'd0,  5'd10, 16'd36);
      12: return enc_i(OP_BEQ,   5'd1,  5'd3,  16'd5);
      13: return enc_i(OP_BEQ,   5'd4,  5'd0,  16'd2);
      14: return enc_r(5'd3, 5'd3, 5'd5, FN_ADD);
      15: return enc_r(5'd3, 5'd3, 5'd5, FN_ADD);
      16: return enc_i(OP_STORE, 5'd10, 5'd7,  16'hFFFC);
      17: return enc_i(OP_LOAD,  5'd0,  5'd12, 16'd20);
      18: return enc_j(26'd21);
      19: return enc_r(5'd3, 5'd3, 5'd12, FN_ADD);
      20: return enc_r(5'd3, 5'd3, 5'd12, FN_ADD);
      21: return enc_i(OP_BEQ,   5'd0,  5'd0,  16'hFFFF);
      default: return 32'd0;
    endcase
  endfunction

endpackage

// File: rtl/sc_main_decode.sv
module sc_main_decode
  import sc_core_pkg::*;
(
  input  logic [5:0] opcode,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl = '0;
    ctrl.alu_op = ALUOP_ADD;
    case (opcode)
      OP_RTYPE: begin
        ctrl.reg_write = 1'b1;
        ctrl.reg_dst   = 1'b1;
        ctrl.alu_op    = ALUOP_FUNCT;
      end
      OP_LOAD: begin
        ctrl.reg_write  = 1'b1;
        ctrl.alu_src    = 1'b1;
        ctrl.mem_to_reg = 1'b1;
        ctrl.mem_read   = 1'b1;
      end
      OP_STORE: begin
        ctrl.alu_src   = 1'b1;
        ctrl.mem_write = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.alu_op = ALUOP_SUB;
      end
      OP_JUMP: begin
        ctrl.jump = 1'b1;
      end
      default: ;
    endcase
  end

  // R6: a store never also writes back; at most one memory direction
  always_comb begin
    assert_store_no_wb_R6: assert (!(ctrl.mem_write && ctrl.reg_write));
    assert_mem_excl_R6: assert ($onehot0({ctrl.mem_read, ctrl.mem_write}));
  end

endmodule

// File: rtl/sc_alu_decode.sv
module sc_alu_decode
  import sc_core_pkg::*;
(
  input  alu_op_e    alu_op,
  input  logic [5:0] funct,
  output alu_sel_e   alu_sel
);

  always_comb begin
    case (alu_op)
      ALUOP_ADD: alu_sel = ALU_ADD;
      ALUOP_SUB: alu_sel = ALU_SUB;
      default: begin
        case (funct)
          FN_SUB:  alu_sel = ALU_SUB;
          FN_AND:  alu_sel = ALU_AND;
          FN_OR:   alu_sel = ALU_OR;
          FN_SLT:  alu_sel = ALU_SLT;
          default: alu_sel = ALU_ADD;
        endcase
      end
    endcase
  end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_core_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  alu_sel_e     sel,
  output logic [W-1:0] result,
  output logic         zero
);

  always_comb begin
    case (sel)
      ALU_AND: result = op_a & op_b;
      ALU_OR:  result = op_a | op_b;
      ALU_SUB: result = op_a - op_b;
      ALU_SLT: result = {{(W-1){1'b0}}, ($signed(op_a) < $signed(op_b))};
      default: result = op_a + op_b;
    endcase
  end

  assign zero = (result == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W      = 32,
  parameter int NREGS  = 32,
  localparam int AW    = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  input  logic [AW-1:0] ra_dbg,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b,
  output logic [W-1:0]  rd_dbg,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);

  logic [W-1:0] regs [1:NREGS-1];
  logic         wr_en;

  // R9: register 0 has no storage; its writes are dropped here
  assign wr_en = we && (wa != '0);

  always_ff @(posedge clk) begin
    if (wr_en) regs[wa] <= wd;
  end

  assign rd_a   = (ra_a   == '0) ? '0 : regs[ra_a];
  assign rd_b   = (ra_b   == '0) ? '0 : regs[ra_b];
  assign rd_dbg = (ra_dbg == '0) ? '0 : regs[ra_dbg];

  assert_reg_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wa != '0) |=> regs[$past(wa)] == $past(wd));

endmodule

// File: rtl/sc_cpu_core.sv
module sc_cpu_core
  import sc_core_pkg::*;
#(
  parameter int IMEM_WORDS = 32,
  parameter int DMEM_WORDS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  dbg_sel,
  output logic [31:0] dbg_reg,
  output logic [31:0] dbg_pc
);

  localparam int IIDX_W = $clog2(IMEM_WORDS);
  localparam int DIDX_W = $clog2(DMEM_WORDS);

  // Reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign core_rst_n = rst_pipe[1];

  // Program counter
  logic [XLEN-1:0] pc_q, pc_d;

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) pc_q <= '0;
    else             pc_q <= pc_d;
  end

  // Instruction memory: constant table
  logic [31:0] imem_rom [IMEM_WORDS];
  for (genvar g = 0; g < IMEM_WORDS; g++) begin : g_rom
    assign imem_rom[g] = boot_word(g);
  end

  logic [31:0] instr;
  assign instr = imem_rom[pc_q[IIDX_W+1:2]];

  logic [5:0]  f_op, f_fn;
  logic [4:0]  f_rs, f_rt, f_rd, f_sh;
  logic [15:0] f_imm;
  logic [25:0] f_tgt;
  assign f_op  = instr[31:26];
  assign f_rs  = instr[25:21];
  assign f_rt  = instr[20:16];
  assign f_rd  = instr[15:11];
  assign f_sh  = instr[10:6];
  assign f_fn  = instr[5:0];
  assign f_imm = instr[15:0];
  assign f_tgt = instr[25:0];

  ctrl_t    ctrl;
  alu_sel_e alu_sel;

  sc_main_decode u_main_dec (.opcode(f_op), .ctrl(ctrl));
  sc_alu_decode  u_alu_dec  (.alu_op(ctrl.alu_op), .funct(f_fn), .alu_sel(alu_sel));

  // Register file
  logic [XLEN-1:0] rs_data, rt_data, wb_data;
  logic [4:0]      wb_addr;

  assign wb_addr = ctrl.reg_dst ? f_rd : f_rt;

  sc_regfile #(.W(XLEN), .NREGS(32)) u_regs (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .ra_a   (f_rs),
    .ra_b   (f_rt),
    .ra_dbg (dbg_sel),
    .rd_a   (rs_data),
    .rd_b   (rt_data),
    .rd_dbg (dbg_reg),
    .we     (ctrl.reg_write),
    .wa     (wb_addr),
    .wd     (wb_data)
  );

  // Execute
  logic [XLEN-1:0] imm_sx, alu_b, alu_y;
  logic            alu_zero;

  assign imm_sx = {{(XLEN-16){f_imm[15]}}, f_imm};
  assign alu_b  = ctrl.alu_src ? imm_sx : rt_data;

  sc_alu #(.W(XLEN)) u_alu (
    .op_a   (rs_data),
    .op_b   (alu_b),
    .sel    (alu_sel),
    .result (alu_y),
    .zero   (alu_zero)
  );

  // Data memory: seeded by reset, one write port, combinational read
  logic [XLEN-1:0]   dmem_q [DMEM_WORDS];
  logic [DIDX_W-1:0] d_idx;
  logic              dmem_we;
  logic [XLEN-1:0]   d_rdata;

  assign d_idx   = alu_y[DIDX_W+1:2];
  assign dmem_we = ctrl.mem_write;
  assign d_rdata = dmem_q[d_idx];

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      for (int i = 0; i < DMEM_WORDS; i++) dmem_q[i] <= seed_word(i);
    end else if (dmem_we) begin
      dmem_q[d_idx] <= rt_data;
    end
  end

  assign wb_data = ctrl.mem_to_reg ? d_rdata : alu_y;

  // Next PC
  logic [XLEN-1:0] pc_plus4, br_target, jmp_target;
  logic            br_taken;

  assign pc_plus4   = pc_q + 32'd4;
  assign br_target  = pc_plus4 + {imm_sx[XLEN-3:0], 2'b00};
  assign jmp_target = {pc_plus4[31:28], f_tgt, 2'b00};
  assign br_taken   = ctrl.branch && alu_zero;

  always_comb begin
    if (ctrl.jump)     pc_d = jmp_target;
    else if (br_taken) pc_d = br_target;
    else               pc_d = pc_plus4;
  end

  assign dbg_pc = pc_q;

  logic unused_bits;
  assign unused_bits = ^{f_sh, ctrl.mem_read, imm_sx[XLEN-1:XLEN-2]};

  // Assertions
  assert_pc_step_R3: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!ctrl.jump && !br_taken) |=> pc_q == $past(pc_q) + 32'd4);

  assert_branch_target_R7: assert property (@(posedge clk) disable iff (!core_rst_n)
    br_taken |=> pc_q == $past(pc_q) + 32'd4 + {$past(imm_sx[XLEN-3:0]), 2'b00});

  assert_jump_region_R8: assert property (@(posedge clk) disable iff (!core_rst_n)
    ctrl.jump |=> (pc_q[1:0] == 2'b00) && (pc_q[31:28] == $past(pc_plus4[31:28])));

  assert_store_commit_R6: assert property (@(posedge clk) disable iff (!core_rst_n)
    dmem_we |=> dmem_q[$past(d_idx)] == $past(rt_data));

endmodule

// File: tb/sc_cpu_core_test.sv
`timescale 1ns/1ps
module sc_cpu_core_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  dbg_sel;
  logic [31:0] dbg_reg;
  logic [31:0] dbg_pc;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  sc_cpu_core uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .dbg_sel (dbg_sel),
    .dbg_reg (dbg_reg),
    .dbg_pc  (dbg_pc)
  );

  // Expected instruction-word path after the first step (program in the package)
  int exp_path [17] = '{1,2,3,4,5,6,7,8,9,10,11,12,13,16,17,18,21};

  function automatic logic [31:0] seed(input int i);
    return 32'(i * 8 - 20);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_reg(input logic [4:0] r, input string req, input logic [31:0] exp);
    @(negedge clk);
    dbg_sel = r;
    #1;
    chk(req, dbg_reg, exp);
  endtask

  // R1: reset holds PC at zero, first step lands on 4
  task automatic t_reset_start();
    rst_n   = 1'b0;
    dbg_sel = 5'd0;
    repeat (3) @(negedge clk);
    chk("R1 pc in reset", dbg_pc, 32'd0);
    rst_n = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (dbg_pc != 32'd0) break;
    end
    chk("R1 first step", dbg_pc, 32'd4);
  endtask

  // R3 sequencing, R7 branches, R8 jump
  task automatic t_trace();
    for (int s = 1; s < 17; s++) begin
      @(negedge clk);
      if (exp_path[s] == 16)      chk("R7 taken forward branch", dbg_pc, 32'(exp_path[s] * 4));
      else if (exp_path[s] == 21) chk("R8 jump target", dbg_pc, 32'(exp_path[s] * 4));
      else if (exp_path[s] == 13) chk("R7 untaken branch", dbg_pc, 32'(exp_path[s] * 4));
      else                        chk("R3 pc step", dbg_pc, 32'(exp_path[s] * 4));
    end
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R7 backward branch loop", dbg_pc, 32'd84);
    end
  endtask

  task automatic t_alu_results();
    read_reg(5'd4, "R4 add", seed(0) + seed(5));
    read_reg(5'd5, "R4 sub kept after skipped writes", seed(5) - seed(2));
    read_reg(5'd6, "R4 and", seed(0) & seed(5));
    read_reg(5'd7, "R4 or", seed(0) | seed(5));
    read_reg(5'd8, "R4 slt signed true", 32'd1);
    read_reg(5'd9, "R4 slt signed false", 32'd0);
  endtask

  task automatic t_loads();
    read_reg(5'd1, "R5 load word0 / R2 seed", seed(0));
    read_reg(5'd2, "R5 load word2 / R2 seed", seed(2));
    read_reg(5'd3, "R5 load word5 / R2 seed", seed(5));
  endtask

  task automatic t_store_reload();
    read_reg(5'd10, "R6 store then reload", seed(5) - seed(2));
    read_reg(5'd12, "R6 negative offset store", seed(0) | seed(5));
  endtask

  task automatic t_zero_reg();
    read_reg(5'd0, "R9 zero register", 32'd0);
    read_reg(5'd9, "R10 debug select", 32'd0);
    read_reg(5'd8, "R10 debug select", 32'd1);
  endtask

  // R1 asynchronous assertion mid-run, R2 reseed after a run
  task automatic t_midrun_reset();
    @(negedge clk);
    #1;
    rst_n = 1'b0;
    #0.5;
    chk("R1 async pc clear", dbg_pc, 32'd0);
    repeat (2) @(negedge clk);
    chk("R1 pc held in reset", dbg_pc, 32'd0);
    rst_n = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (dbg_pc != 32'd0) break;
    end
    chk("R1 restart step", dbg_pc, 32'd4);
    t_trace();
    read_reg(5'd3, "R2 reseeded word5", seed(5));
    read_reg(5'd12, "R6 overwrite after reseed", seed(0) | seed(5));
  endtask

  initial begin
    t_reset_start();
    t_trace();
    t_alu_results();
    t_loads();
    t_store_reload();
    t_zero_reg();
    t_midrun_reset();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule